// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Saturation

This block sits next to a processor's 16x16 multiplier. When a multiply is issued whose destination address falls inside a small reserved window at the bottom of the register space, the unit does not perform a normal register write. Instead it adds the 32-bit product into a private 32-bit accumulator. Multiplies aimed at any other destination pass by without touching it.

Operands can be unsigned integers, signed integers or signed Q15 fractions. A small control register sets the mode. One bit turns on clamping at the numeric limits, and another bit turns on fractional scaling for signed operands. A sticky flag records that the sum has overflowed, and a write to the control register clears it.

The add path is fed by a three-way base selector. It can pick the running sum (accumulate), zero (the product starts a new sum) or a directly written value (load or clear). The result is registered, so the new value appears one clock after the request.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset, `acc_q` is 0 and `ctl_rdata` is 0, so saturation, fractional mode and the overflow flag are all off.
- R2: A request with `req_valid`=1 and `req_dst` in 0x00..0x0F updates `acc_q` at the next rising clock edge.
- R3: A request whose `req_dst` is 0x10 or above, or a cycle with no request and no write, leaves `acc_q` unchanged.
- R4: With `req_signed`=0, the operands are unsigned and the zero-extended 32-bit product is added as an unsigned number.
- R5: With `req_signed`=1 and fractional mode off, the two's-complement product is added as a signed number.
- R6: With `req_signed`=1 and fractional mode on (`ctl_rdata[1]`), the product is doubled. 0x8000 x 0x8000 gives 0x7FFFFFFF. Fractional mode has no effect when `req_signed`=0.
- R7: With saturation on (`ctl_rdata[0]`), a signed sum above the maximum becomes 0x7FFFFFFF and a signed sum below the minimum becomes 0x80000000.
- R8: With saturation on, an unsigned sum that carries out becomes 0xFFFFFFFF.
- R9: With saturation off, the sum wraps modulo 2^32. Any overflow sets the sticky flag `ctl_rdata[2]`, and the flag stays set until a control write.
- R10: With `req_load`=1, an accepted request writes the product itself into the accumulator, with zero as the base.
- R11: `acc_we`=1 loads `acc_wdata` into the accumulator at the next edge. A request in the same cycle is ignored.
- R12: `ctl_we`=1 stores `ctl_wdata[0]` as the saturation enable and `ctl_wdata[1]` as the fractional enable, and clears the overflow flag. This takes priority over an overflow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Multiply request present |
| req_dst | input | 8 | Destination address of the multiply |
| req_a | input | 16 | First operand |
| req_b | input | 16 | Second operand |
| req_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| req_load | input | 1 | 1 = product replaces the accumulator |
| acc_we | input | 1 | Direct accumulator write |
| acc_wdata | input | 32 | Value for the direct write |
| acc_q | output | 32 | Accumulator contents |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 2 | {fractional enable, saturation enable} |
| ctl_rdata | output | 3 | {overflow flag, fractional enable, saturation enable} |

## Verification
The accumulator is driven with unsigned, signed and fractional products and compared with a reference model on every cycle. Sums are pushed just past each of the three limits, once with clamping on and once with it off. This separates clamping from wrapping and shows the sticky flag being set. The corner operand 0x8000 x 0x8000 is applied in every mode, which isolates the fractional special case from plain doubling. A long random phase then mixes in-window and out-of-window destinations, loads, direct writes and control writes, including collisions in the same cycle, to expose priority errors.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W  = 16;
  localparam int ACC_W = 2 * OP_W;
  localparam logic [OP_W-1:0]  OP_MIN  = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_WR   = 2'd2
  } base_sel_e;

  typedef struct packed {
    logic ovf;
    logic frac;
    logic sat;
  } ctl_t;

  typedef struct packed {
    logic             ovf;
    logic [ACC_W-1:0] val;
  } sum_t;

  // Product in the selected number format.
  function automatic logic [ACC_W-1:0] form_product(
      input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
      input logic sgn, input logic frac);
    logic signed [ACC_W-1:0] sp;
    logic [ACC_W-1:0] up;
    sp = $signed(a) * $signed(b);
    up = a * b;
    if (!sgn) return up;
    if (frac) begin
      if (a == OP_MIN && b == OP_MIN) return ACC_MAX;
      return ACC_W'(sp <<< 1);
    end
    return sp;
  endfunction

  // Base plus addend, with overflow detection and optional clamping.
  function automatic sum_t add_clamp(
      input logic [ACC_W-1:0] base, input logic [ACC_W-1:0] addend,
      input logic sgn, input logic sat);
    logic [ACC_W:0] s;
    sum_t r;
    if (sgn) begin
      s = {base[ACC_W-1], base} + {addend[ACC_W-1], addend};
      r.ovf = s[ACC_W] ^ s[ACC_W-1];
      if (r.ovf && sat) r.val = s[ACC_W] ? ACC_MIN : ACC_MAX;
      else              r.val = s[ACC_W-1:0];
    end else begin
      s = {1'b0, base} + {1'b0, addend};
      r.ovf = s[ACC_W];
      r.val = (r.ovf && sat) ? {ACC_W{1'b1}} : s[ACC_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/mac_product.sv
module mac_product
  import mac_pkg::*;
(
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic             sgn,
  input  logic             frac,
  output logic [ACC_W-1:0] product,
  output logic             frac_min
);
  always_comb begin
    product  = form_product(a, b, sgn, frac);
    frac_min = sgn && frac && (a == OP_MIN) && (b == OP_MIN);
  end
endmodule

// File: rtl/mac_accum_path.sv
module mac_accum_path
  import mac_pkg::*;
(
  input  base_sel_e        sel,
  input  logic [ACC_W-1:0] acc_cur,
  input  logic [ACC_W-1:0] wr_val,
  input  logic [ACC_W-1:0] product,
  input  logic             sgn,
  input  logic             sat,
  output logic [ACC_W-1:0] acc_next,
  output logic             ovf_evt
);
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] addend;
  sum_t             res;

  always_comb begin
    unique case (sel)
      SEL_ACC:  base = acc_cur;
      SEL_ZERO: base = '0;
      SEL_WR:   base = wr_val;
      default:  base = acc_cur;
    endcase
    addend   = (sel == SEL_WR) ? '0 : product;
    res      = add_clamp(base, addend, sgn, sat);
    acc_next = res.val;
    ovf_evt  = res.ovf && (sel != SEL_WR);
  end
endmodule

// File: rtl/mac_ctl_reg.sv
module mac_ctl_reg
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  input  logic       ovf_set,
  output ctl_t       ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.sat  <= wdata[0];
      ctl.frac <= wdata[1];
      ctl.ovf  <= 1'b0;
    end else if (ovf_set) begin
      ctl.ovf  <= 1'b1;
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int DST_W    = 8,
  parameter int WIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DST_W-1:0]  req_dst,
  input  logic [OP_W-1:0]   req_a,
  input  logic [OP_W-1:0]   req_b,
  input  logic              req_signed,
  input  logic              req_load,
  input  logic              acc_we,
  input  logic [ACC_W-1:0]  acc_wdata,
  output logic [ACC_W-1:0]  acc_q,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  output logic [2:0]        ctl_rdata
);
  localparam int HI_W = DST_W - WIN_BITS;

  ctl_t             ctl;
  logic             hit_w;
  logic             upd_w;
  logic             ovf_evt_w;
  logic             ovf_set_w;
  logic             frac_min_w;
  logic [ACC_W-1:0] product_w;
  logic [ACC_W-1:0] acc_next_w;
  base_sel_e        sel_w;

  assign hit_w     = req_valid && (req_dst[DST_W-1:WIN_BITS] == {HI_W{1'b0}});
  assign upd_w     = acc_we || hit_w;
  assign sel_w     = acc_we ? SEL_WR : (req_load ? SEL_ZERO : SEL_ACC);
  assign ovf_set_w = hit_w && !acc_we && ovf_evt_w;

  mac_product u_prod (
    .a        (req_a),
    .b        (req_b),
    .sgn      (req_signed),
    .frac     (ctl.frac),
    .product  (product_w),
    .frac_min (frac_min_w)
  );

  mac_accum_path u_path (
    .sel      (sel_w),
    .acc_cur  (acc_q),
    .wr_val   (acc_wdata),
    .product  (product_w),
    .sgn      (req_signed),
    .sat      (ctl.sat),
    .acc_next (acc_next_w),
    .ovf_evt  (ovf_evt_w)
  );

  mac_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .ovf_set (ovf_set_w),
    .ctl     (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (upd_w) acc_q <= acc_next_w;
  end

  assign ctl_rdata = {ctl.ovf, ctl.frac, ctl.sat};
endmodule

// File: rtl/mac_acc_checker.sv
module mac_acc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hit,
  input logic        acc_we,
  input logic [31:0] acc_wdata,
  input logic [31:0] acc_q,
  input logic        ctl_we,
  input logic [1:0]  ctl_wdata,
  input logic [2:0]  ctl_rdata,
  input logic        ovf_evt,
  input logic        signed_mode,
  input logic        frac_min,
  input logic [31:0] product
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !acc_we) |=> $stable(acc_q));

  assert_frac_corner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frac_min |-> (product == 32'h7FFF_FFFF));

  assert_signed_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !acc_we && ctl_rdata[0] && ovf_evt && signed_mode)
    |=> (acc_q == 32'h7FFF_FFFF || acc_q == 32'h8000_0000));

  assert_unsigned_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !acc_we && ctl_rdata[0] && ovf_evt && !signed_mode)
    |=> (acc_q == 32'hFFFF_FFFF));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2] && !ctl_we) |=> ctl_rdata[2]);

  assert_direct_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> (acc_q == $past(acc_wdata)));

  assert_ctl_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata == {1'b0, $past(ctl_wdata)}));
endmodule

bind mac_acc_unit mac_acc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit         (hit_w),
  .acc_we      (acc_we),
  .acc_wdata   (acc_wdata),
  .acc_q       (acc_q),
  .ctl_we      (ctl_we),
  .ctl_wdata   (ctl_wdata),
  .ctl_rdata   (ctl_rdata),
  .ovf_evt     (ovf_evt_w),
  .signed_mode (req_signed),
  .frac_min    (frac_min_w),
  .product     (product_w)
);

// File: tb/mac_acc_unit_bench.sv
module mac_acc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_dst = '0;
  logic [15:0] req_a = '0;
  logic [15:0] req_b = '0;
  logic        req_signed = 1'b0;
  logic        req_load = 1'b0;
  logic        acc_we = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_q;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_wdata = '0;
  logic [2:0]  ctl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_acc = '0;
  bit m_sat = 0, m_frac = 0, m_ovf = 0;

  always #2 clk = ~clk;

  mac_acc_unit u_mac_acc_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_a(req_a), .req_b(req_b), .req_signed(req_signed), .req_load(req_load),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_q(acc_q),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  function automatic longint ref_product(logic [15:0] a, logic [15:0] b, bit sgn, bit frac);
    longint p;
    if (!sgn) return longint'(a) * longint'(b);
    p = longint'($signed(a)) * longint'($signed(b));
    if (frac) begin
      if (p == 64'sd1073741824) return 64'sd2147483647;
      return p * 2;
    end
    return p;
  endfunction

  // Advance the model by one clock using the inputs now driven.
  task automatic model_step();
    longint p, s;
    bit hit, ov;
    hit = req_valid && (req_dst < 8'h10);
    ov = 0;
    if (acc_we) begin
      m_acc = acc_wdata;
    end else if (hit) begin
      p = ref_product(req_a, req_b, req_signed, m_frac);
      if (req_signed) begin
        s = (req_load ? 64'sd0 : longint'($signed(m_acc))) + p;
        if (s > 64'sd2147483647) begin ov = 1; m_acc = m_sat ? 32'h7FFF_FFFF : s[31:0]; end
        else if (s < -64'sd2147483648) begin ov = 1; m_acc = m_sat ? 32'h8000_0000 : s[31:0]; end
        else m_acc = s[31:0];
      end else begin
        s = (req_load ? 64'sd0 : longint'(m_acc)) + p;
        if (s > 64'sd4294967295) begin ov = 1; m_acc = m_sat ? 32'hFFFF_FFFF : s[31:0]; end
        else m_acc = s[31:0];
      end
    end
    if (ctl_we) begin
      m_sat = ctl_wdata[0]; m_frac = ctl_wdata[1]; m_ovf = 0;
    end else if (ov) begin
      m_ovf = 1;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (acc_q !== m_acc || ctl_rdata !== {m_ovf, m_frac, m_sat}) begin
      errors++;
      $display("FAIL %s: acc=%h ctl=%b expected acc=%h ctl=%b", tag, acc_q, ctl_rdata,
               m_acc, {m_ovf, m_frac, m_sat});
    end
  endtask

  // Called at a falling edge with inputs set; checks after the next rising edge.
  task automatic tick(string tag);
    model_step();
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
    req_valid = 0; acc_we = 0; ctl_we = 0; req_load = 0;
  endtask

  task automatic mul(string tag, logic [7:0] d, logic [15:0] a, logic [15:0] b,
                     bit sgn, bit load);
    req_valid = 1; req_dst = d; req_a = a; req_b = b; req_signed = sgn; req_load = load;
    tick(tag);
  endtask

  task automatic wr_acc(string tag, logic [31:0] v);
    acc_we = 1; acc_wdata = v; tick(tag);
  endtask

  task automatic wr_ctl(string tag, bit frac, bit sat);
    ctl_we = 1; ctl_wdata = {frac, sat}; tick(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    wr_ctl("R12 control clear", 0, 0);
    // R10 and R4: unsigned load, then unsigned accumulate
    mul("R10 load unsigned", 8'h03, 16'hFFFF, 16'hFFFF, 0, 1);
    mul("R4 unsigned add", 8'h0F, 16'd3, 16'd5, 0, 0);
    // R3: outside the window and idle cycle
    mul("R3 dst 0x10", 8'h10, 16'd100, 16'd100, 0, 0);
    mul("R3 dst 0x80", 8'h80, 16'd7, 16'd7, 1, 0);
    tick("R3 idle");
    // R5: signed integer, R2 window edge 0x00
    mul("R5 signed load", 8'h00, 16'hFFFD, 16'd7, 1, 1);
    mul("R5 signed add", 8'h01, 16'h8000, 16'h7FFF, 1, 0);
    mul("R5 min*min int", 8'h02, 16'h8000, 16'h8000, 1, 1);
    // R6: fractional mode
    wr_ctl("R12 frac on", 1, 0);
    mul("R6 half*half", 8'h04, 16'h4000, 16'h4000, 1, 1);
    mul("R6 -1*-1 corner", 8'h04, 16'h8000, 16'h8000, 1, 1);
    mul("R6 unsigned ignores frac", 8'h04, 16'h8000, 16'h8000, 0, 1);
    // R7: signed clamp
    wr_ctl("R12 sat on", 0, 1);
    wr_acc("R11 preload", 32'h7FFF_FFF0);
    mul("R7 positive clamp", 8'h05, 16'h7FFF, 16'h7FFF, 1, 0);
    wr_ctl("R12 clears flag", 0, 1);
    wr_acc("R11 preload", 32'h8000_0010);
    mul("R7 negative clamp", 8'h05, 16'h8001, 16'h7FFF, 1, 0);
    // R8: unsigned clamp
    wr_acc("R11 preload", 32'hFFFF_FF00);
    mul("R8 unsigned clamp", 8'h06, 16'h0100, 16'h0100, 0, 0);
    // R9: wrap and sticky flag
    wr_ctl("R12 sat off", 0, 0);
    wr_acc("R11 preload", 32'hFFFF_FF00);
    mul("R9 unsigned wrap", 8'h07, 16'h0100, 16'h0100, 0, 0);
    mul("R9 flag sticky", 8'h07, 16'd1, 16'd1, 0, 0);
    wr_acc("R9 flag survives acc write", 32'h7FFF_FFFF);
    mul("R9 signed wrap", 8'h08, 16'd1, 16'd1, 1, 0);
    // R11: write beats same-cycle request
    req_valid = 1; req_dst = 8'h01; req_a = 16'd9; req_b = 16'd9; req_signed = 0;
    acc_we = 1; acc_wdata = 32'h1234_5678;
    tick("R11 write over request");
    // R12: control write beats same-cycle overflow
    wr_acc("R11 preload", 32'hFFFF_FFFF);
    req_valid = 1; req_dst = 8'h02; req_a = 16'd2; req_b = 16'd2; req_signed = 0;
    ctl_we = 1; ctl_wdata = 2'b00;
    tick("R12 write over overflow");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      req_valid = (r < 70);
      req_dst = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(16, 255)) : 8'($urandom_range(0, 15));
      req_a = 16'($urandom); req_b = 16'($urandom);
      if ($urandom_range(0, 5) == 0) req_a = 16'h8000;
      if ($urandom_range(0, 5) == 0) req_b = 16'h8000;
      req_signed = 1'($urandom);
      req_load = ($urandom_range(0, 9) == 0);
      acc_we = ($urandom_range(0, 15) == 0);
      acc_wdata = $urandom;
      ctl_we = ($urandom_range(0, 19) == 0);
      ctl_wdata = 2'($urandom);
      tick("R2 random mix");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: acc=%h ctl=%b expected run to complete", acc_q, ctl_rdata);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule